// File: doc/BRIEF.md
# Linked-Descriptor Copy Channel Sequencer

This block is the control engine of one memory-to-memory copy channel. Software builds a linked list of copy descriptors in memory and issues a start command with the address of the first one. The sequencer reads each descriptor and then reads the source block into a buffer outside the block. It writes that buffer to the destination and, when the descriptor asks for it, writes a completion word to a programmed address. It then follows the descriptor's next pointer. All traffic goes through a single request/acknowledge memory port that carries address, byte length and direction. The memory fabric and the staging buffer sit outside this block.

Work can be added to a chain that has already ended or is still running. An append command re-reads only the next-pointer word of the most recently fetched descriptor. If that command arrives while the channel is working, the re-read is held until the current descriptor finishes. A reset command that arrives while the channel works is also held until the current descriptor finishes, and it overrides any further chain traversal.

A descriptor is `DESC_W = 8 + LW + 3*AW` bits, returned in one beat on `mem_rdata`. Bits `[AW-1:0]` hold the next pointer, `[2AW-1:AW]` the destination, `[3AW-1:2AW]` the source, `[3AW+LW-1:3AW]` the byte length and the top 8 bits the flags. Flag bit 0 marks a null descriptor and flag bit 1 requests a completion write. An all-zero next pointer ends the chain.

Top module: `cc_copy_chan`

## Requirements
- R1: After reset the channel is idle: `busy`=0, `mem_req`=0, `xfer_status`=3, `err_flags`=0, `done_addr`=0 and both tallies are 0.
- R2: A start command while idle clears `xfer_status` to 0 and `err_flags` to 0. It then issues a read of `DESC_W/8` rounded up bytes at `chain_addr`. A start command while busy has no effect.
- R3: For each valid descriptor the channel reads `len` bytes at the source and then writes `len` bytes at the destination. Each request holds address, length and direction stable until `mem_ack`.
- R4: When flag bit 1 is set, the destination write is followed by a write of `AW/8` bytes at `cmpl_addr`. The word written has bits `[AW-1:6]` equal to the descriptor address bits `[AW-1:6]`, bits `[5:2]` zero and bits `[1:0]` equal to `xfer_status` OR 1. When flag bit 1 is clear, no such write is made.
- R5: After the destination write, `done_addr` holds the address of that descriptor shifted right by 6.
- R6: After a descriptor finishes, a non-zero next pointer starts a fetch of the next descriptor. A zero next pointer with nothing pending returns the channel to idle.
- R7: A descriptor with flag bit 0 set makes no copy and no completion write, ignores its next pointer, and returns the channel to idle.
- R8: A non-null descriptor with any of flag bits 7..2 set makes no copy, sets `err_flags[0]`, and returns the channel to idle.
- R9: A valid-flag descriptor whose length exceeds `CAP_BYTES` makes no copy, sets `err_flags[1]`, and returns the channel to idle. A length equal to `CAP_BYTES` is copied.
- R10: An append command while idle reads `AW/8` bytes at the last fetched descriptor address plus `NEXT_OFFSET`. The low `AW` bits of the reply are the new next pointer. Zero returns the channel to idle; any other value starts a descriptor fetch there.
- R11: An append command while busy is held. After the current descriptor, a non-zero next pointer is followed first, and the held re-read is made once the chain reaches a zero next pointer.
- R12: A reset command while idle sets `xfer_status` to 3. While busy it is held until the current descriptor finishes. At that point the channel goes idle with `xfer_status`=3, its next pointer is not followed and any held append is dropped.
- R13: Each copied descriptor adds its length to `bytes_copied` and 1 to `descs_done`. The counts are updated when the destination write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Start command pulse |
| cmd_append | input | 1 | Append command pulse |
| cmd_reset | input | 1 | Channel reset command pulse |
| chain_addr | input | AW | Address of the first descriptor |
| cmpl_addr | input | AW | Completion word address |
| mem_req | output | 1 | Memory request valid |
| mem_wr | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Request address |
| mem_len | output | LW | Request length in bytes |
| mem_wdata | output | AW | Completion word (valid on completion write) |
| mem_ack | input | 1 | Request accepted and finished |
| mem_rdata | input | DESC_W | Descriptor or next-pointer reply |
| busy | output | 1 | Channel is processing |
| xfer_status | output | 2 | Transfer status code |
| done_addr | output | AW-6 | Last completed descriptor address >> 6 |
| err_flags | output | 2 | bit0 bad flags, bit1 length over limit |
| bytes_copied | output | CNT_W | Total bytes copied |
| descs_done | output | CNT_W | Total descriptors copied |

## Verification
The hardest case to reach is a command that arrives in the middle of a descriptor, because the held append and the held reset only act at the end of the descriptor. The bench watches the stream of memory requests and issues the append or reset only after it has seen the source read go out. In the held-append case it also patches the descriptor's next pointer in its memory model at that moment. This proves that the re-read really goes back to memory rather than using the copy fetched earlier. Random acknowledge delays and random chains with occasional over-length entries then vary where these commands fall.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DFETCH,
    ST_NFETCH,
    ST_SRC_RD,
    ST_DST_WR,
    ST_CMPL_WR
  } cc_state_e;

  localparam int FLAG_W   = 8;
  localparam int FLG_NULL = 0;
  localparam int FLG_CMPL = 1;
endpackage

// File: rtl/cc_desc_reg.sv
module cc_desc_reg
  import cc_pkg::*;
#(
  parameter int AW        = 32,
  parameter int LW        = 16,
  parameter int CAP_BYTES = 4096,
  parameter int DESC_W    = FLAG_W + LW + 3 * AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DESC_W-1:0] rdata,
  output logic              in_null,
  output logic              in_bad,
  output logic              in_long,
  output logic [AW-1:0]     in_next,
  output logic [AW-1:0]     d_src,
  output logic [AW-1:0]     d_dst,
  output logic [AW-1:0]     d_next,
  output logic [LW-1:0]     d_len,
  output logic              d_cmpl
);
  localparam logic [LW-1:0] CAP_L = LW'(CAP_BYTES);

  logic [FLAG_W-1:0] flags;
  logic [LW-1:0]     len_f;

  // field split of the reply beat
  assign flags   = rdata[DESC_W-1 -: FLAG_W];
  assign len_f   = rdata[3*AW +: LW];
  assign in_next = rdata[0 +: AW];
  assign in_null = flags[FLG_NULL];
  assign in_bad  = |flags[FLAG_W-1:2];
  assign in_long = len_f > CAP_L;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_src  <= '0;
      d_dst  <= '0;
      d_next <= '0;
      d_len  <= '0;
      d_cmpl <= 1'b0;
    end else if (load) begin
      d_src  <= rdata[2*AW +: AW];
      d_dst  <= rdata[AW +: AW];
      d_next <= rdata[0 +: AW];
      d_len  <= len_f;
      d_cmpl <= flags[FLG_CMPL];
    end
  end
endmodule

// File: rtl/cc_tally.sv
module cc_tally #(
  parameter int LW    = 16,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [LW-1:0]    len,
  output logic [CNT_W-1:0] bytes_copied,
  output logic [CNT_W-1:0] descs_done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bytes_copied <= '0;
      descs_done   <= '0;
    end else if (en) begin
      bytes_copied <= bytes_copied + CNT_W'(len);
      descs_done   <= descs_done + 1'b1;
    end
  end

  // R13: descriptor count only ever steps by one
  p_count_step_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (descs_done != $past(descs_done)) |-> (descs_done == $past(descs_done) + 1'b1));
endmodule

// File: rtl/cc_fsm.sv
module cc_fsm
  import cc_pkg::*;
#(
  parameter int AW          = 32,
  parameter int LW          = 16,
  parameter int CAP_BYTES   = 4096,
  parameter int NEXT_OFFSET = 8,
  parameter int DESC_BYTES  = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start,
  input  logic          cmd_append,
  input  logic          cmd_reset,
  input  logic [AW-1:0] chain_addr,
  input  logic [AW-1:0] cmpl_addr,
  input  logic          mem_ack,
  input  logic          in_null,
  input  logic          in_bad,
  input  logic          in_long,
  input  logic [AW-1:0] in_next,
  input  logic [AW-1:0] d_src,
  input  logic [AW-1:0] d_dst,
  input  logic [AW-1:0] d_next,
  input  logic [LW-1:0] d_len,
  input  logic          d_cmpl,
  output logic          desc_load,
  output logic          tally_en,
  output logic          mem_req,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [LW-1:0] mem_len,
  output logic [AW-1:0] mem_wdata,
  output logic          busy,
  output logic [1:0]    xfer_status,
  output logic [AW-7:0] done_addr,
  output logic [1:0]    err_flags
);
  localparam logic [LW-1:0] CAP_L   = LW'(CAP_BYTES);
  localparam logic [LW-1:0] DLEN_L  = LW'(DESC_BYTES);
  localparam logic [LW-1:0] PLEN_L  = LW'(AW / 8);
  localparam logic [1:0]    ST_RST  = 2'd3;

  cc_state_e     state_q, state_n;
  logic [AW-1:0] fetch_q, fetch_n;
  logic [AW-1:0] last_q, last_n;
  logic          papp_q, papp_n;
  logic          prst_q, prst_n;
  logic [1:0]    stat_q, stat_n;
  logic [AW-7:0] done_q, done_n;
  logic [1:0]    err_q, err_n;
  logic          pa, pr;

  // held commands including one arriving in this cycle
  assign pa = papp_q | cmd_append;
  assign pr = prst_q | cmd_reset;

  always_comb begin
    state_n = state_q;
    fetch_n = fetch_q;
    last_n  = last_q;
    papp_n  = papp_q;
    prst_n  = prst_q;
    stat_n  = stat_q;
    done_n  = done_q;
    err_n   = err_q;
    if (state_q != ST_IDLE) begin
      papp_n = pa;
      prst_n = pr;
    end
    case (state_q)
      ST_IDLE: begin
        if (cmd_start) begin
          state_n = ST_DFETCH;
          fetch_n = chain_addr;
          stat_n  = 2'd0;
          err_n   = 2'd0;
        end else if (cmd_append) begin
          state_n = ST_NFETCH;
        end else if (cmd_reset) begin
          stat_n = ST_RST;
        end
      end
      ST_DFETCH: if (mem_ack) begin
        last_n = fetch_q;
        if (in_null || in_bad || in_long) begin
          state_n = ST_IDLE;
          papp_n  = 1'b0;
          prst_n  = 1'b0;
          if (pr) stat_n = ST_RST;
          if (!in_null && in_bad) err_n[0] = 1'b1;
          else if (!in_null && in_long) err_n[1] = 1'b1;
        end else begin
          state_n = ST_SRC_RD;
        end
      end
      ST_NFETCH: if (mem_ack) begin
        if (in_next == '0) begin
          state_n = ST_IDLE;
          papp_n  = 1'b0;
          prst_n  = 1'b0;
          if (pr) stat_n = ST_RST;
        end else begin
          state_n = ST_DFETCH;
          fetch_n = in_next;
        end
      end
      ST_SRC_RD: if (mem_ack) state_n = ST_DST_WR;
      default: begin
        // ST_DST_WR and ST_CMPL_WR
        if (mem_ack) begin
          if (state_q == ST_DST_WR) done_n = last_q[AW-1:6];
          if (state_q == ST_DST_WR && d_cmpl) begin
            state_n = ST_CMPL_WR;
          end else if (pr) begin
            state_n = ST_IDLE;
            stat_n  = ST_RST;
            papp_n  = 1'b0;
            prst_n  = 1'b0;
          end else if (d_next != '0) begin
            state_n = ST_DFETCH;
            fetch_n = d_next;
          end else if (pa) begin
            state_n = ST_NFETCH;
            papp_n  = 1'b0;
          end else begin
            state_n = ST_IDLE;
            papp_n  = 1'b0;
            prst_n  = 1'b0;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      fetch_q <= '0;
      last_q  <= '0;
      papp_q  <= 1'b0;
      prst_q  <= 1'b0;
      stat_q  <= ST_RST;
      done_q  <= '0;
      err_q   <= '0;
    end else begin
      state_q <= state_n;
      fetch_q <= fetch_n;
      last_q  <= last_n;
      papp_q  <= papp_n;
      prst_q  <= prst_n;
      stat_q  <= stat_n;
      done_q  <= done_n;
      err_q   <= err_n;
    end
  end

  // request decode
  always_comb begin
    mem_addr = '0;
    mem_len  = '0;
    case (state_q)
      ST_DFETCH:  begin mem_addr = fetch_q;                   mem_len = DLEN_L; end
      ST_NFETCH:  begin mem_addr = last_q + AW'(NEXT_OFFSET); mem_len = PLEN_L; end
      ST_SRC_RD:  begin mem_addr = d_src;                     mem_len = d_len;  end
      ST_DST_WR:  begin mem_addr = d_dst;                     mem_len = d_len;  end
      ST_CMPL_WR: begin mem_addr = cmpl_addr;                 mem_len = PLEN_L; end
      default: ;
    endcase
  end

  assign mem_req     = (state_q != ST_IDLE);
  assign mem_wr      = (state_q == ST_DST_WR) || (state_q == ST_CMPL_WR);
  assign mem_wdata   = {done_q, 4'b0000, stat_q[1], 1'b1};
  assign desc_load   = (state_q == ST_DFETCH) && mem_ack;
  assign tally_en    = (state_q == ST_SRC_RD) && mem_ack;
  assign busy        = (state_q != ST_IDLE);
  assign xfer_status = stat_q;
  assign done_addr   = done_q;
  assign err_flags   = err_q;

  p_hold_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_len) && $stable(mem_wr)));

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && !busy) |=> (busy && xfer_status == 2'd0 && mem_addr == $past(chain_addr)));

  p_reset_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_reset && !cmd_start && !cmd_append && !busy) |=> (!busy && xfer_status == ST_RST));

  p_cmpl_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CMPL_WR) |-> (mem_wr && mem_wdata[0] && mem_wdata[AW-1:6] == last_q[AW-1:6]));

  p_len_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SRC_RD) |-> (mem_len <= CAP_L));
endmodule

// File: rtl/cc_copy_chan.sv
module cc_copy_chan
  import cc_pkg::*;
#(
  parameter int AW          = 32,
  parameter int LW          = 16,
  parameter int CAP_BYTES   = 4096,
  parameter int CNT_W       = 32,
  parameter int NEXT_OFFSET = 8,
  parameter int DESC_W      = FLAG_W + LW + 3 * AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              cmd_append,
  input  logic              cmd_reset,
  input  logic [AW-1:0]     chain_addr,
  input  logic [AW-1:0]     cmpl_addr,
  output logic              mem_req,
  output logic              mem_wr,
  output logic [AW-1:0]     mem_addr,
  output logic [LW-1:0]     mem_len,
  output logic [AW-1:0]     mem_wdata,
  input  logic              mem_ack,
  input  logic [DESC_W-1:0] mem_rdata,
  output logic              busy,
  output logic [1:0]        xfer_status,
  output logic [AW-7:0]     done_addr,
  output logic [1:0]        err_flags,
  output logic [CNT_W-1:0]  bytes_copied,
  output logic [CNT_W-1:0]  descs_done
);
  localparam int DESC_BYTES = (DESC_W + 7) / 8;

  logic          desc_load, tally_en;
  logic          in_null, in_bad, in_long, d_cmpl;
  logic [AW-1:0] in_next, d_src, d_dst, d_next;
  logic [LW-1:0] d_len;

  cc_desc_reg #(.AW(AW), .LW(LW), .CAP_BYTES(CAP_BYTES), .DESC_W(DESC_W)) u_desc (
    .clk, .rst_n, .load(desc_load), .rdata(mem_rdata),
    .in_null, .in_bad, .in_long, .in_next,
    .d_src, .d_dst, .d_next, .d_len, .d_cmpl
  );

  cc_fsm #(.AW(AW), .LW(LW), .CAP_BYTES(CAP_BYTES), .NEXT_OFFSET(NEXT_OFFSET),
           .DESC_BYTES(DESC_BYTES)) u_fsm (
    .clk, .rst_n, .cmd_start, .cmd_append, .cmd_reset, .chain_addr, .cmpl_addr,
    .mem_ack, .in_null, .in_bad, .in_long, .in_next,
    .d_src, .d_dst, .d_next, .d_len, .d_cmpl,
    .desc_load, .tally_en, .mem_req, .mem_wr, .mem_addr, .mem_len, .mem_wdata,
    .busy, .xfer_status, .done_addr, .err_flags
  );

  cc_tally #(.LW(LW), .CNT_W(CNT_W)) u_tally (
    .clk, .rst_n, .en(tally_en), .len(d_len), .bytes_copied, .descs_done
  );
endmodule

// File: tb/cc_copy_chan_tb.sv
module cc_copy_chan_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, LW = 16, CAP = 4096, NOFS = 8;
  localparam int DW = 8 + LW + 3 * AW;
  localparam int DB = (DW + 7) / 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_start = 0, cmd_append = 0, cmd_reset = 0;
  logic [AW-1:0] chain_addr = '0, cmpl_addr = 32'h0000_F000;
  logic mem_req, mem_wr, mem_ack = 0, busy;
  logic [AW-1:0] mem_addr, mem_wdata;
  logic [LW-1:0] mem_len;
  logic [DW-1:0] mem_rdata = '0;
  logic [1:0] xfer_status, err_flags;
  logic [AW-7:0] done_addr;
  logic [31:0] bytes_copied, descs_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  cc_copy_chan u_dut (
    .clk, .rst_n, .cmd_start, .cmd_append, .cmd_reset, .chain_addr, .cmpl_addr,
    .mem_req, .mem_wr, .mem_addr, .mem_len, .mem_wdata, .mem_ack, .mem_rdata,
    .busy, .xfer_status, .done_addr, .err_flags, .bytes_copied, .descs_done
  );

  int total = 0, bad = 0;
  logic [DW-1:0] dmem [0:63];
  logic        g_wr [0:255];
  logic [31:0] g_addr [0:255], g_wd [0:255];
  logic [15:0] g_len [0:255];
  int g_n = 0;
  logic        e_wr [0:255], e_cw [0:255];
  logic [31:0] e_addr [0:255], e_wd [0:255];
  logic [15:0] e_len [0:255];
  int e_n = 0;
  logic [1:0]  e_status = 2'd3, e_err = 2'd0;
  logic [31:0] e_bytes = 0, e_descs = 0;
  logic [25:0] e_done = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory responder: random latency, logs each request once
  initial begin
    bit logged = 0;
    int dly = 0;
    forever begin
      @(negedge clk);
      mem_ack = 1'b0;
      if (mem_req && !logged) begin
        g_wr[g_n] = mem_wr; g_addr[g_n] = mem_addr; g_len[g_n] = mem_len; g_wd[g_n] = mem_wdata;
        g_n++;
        logged = 1;
        dly = $urandom % 3;
      end
      if (logged) begin
        if (dly == 0) begin
          if (mem_addr[5:0] == 6'(NOFS)) mem_rdata = {{(DW-32){1'b0}}, dmem[mem_addr[11:6]][31:0]};
          else mem_rdata = dmem[mem_addr[11:6]];
          mem_ack = 1'b1;
          logged = 0;
        end else dly--;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic [DW-1:0] mk(input logic [7:0] f, input logic [15:0] l,
      input logic [31:0] s, input logic [31:0] d, input logic [31:0] n);
    return {f, l, s, d, n};
  endfunction

  task automatic push(input logic w, input logic [31:0] a, input logic [15:0] l,
                      input logic [31:0] wd, input logic cw);
    e_wr[e_n] = w; e_addr[e_n] = a; e_len[e_n] = l; e_wd[e_n] = wd; e_cw[e_n] = cw; e_n++;
  endtask

  task automatic add_desc(input logic [31:0] a, output logic [31:0] nxt, output bit cont);
    logic [DW-1:0] d;
    d = dmem[a[11:6]];
    push(0, a, 16'(DB), 0, 0);
    nxt = d[31:0]; cont = 0;
    if (d[112]) return;                                   // null
    if (|d[119:114]) begin e_err[0] = 1; return; end       // bad flags
    if (d[111:96] > 16'(CAP)) begin e_err[1] = 1; return; end
    push(0, d[95:64], d[111:96], 0, 0);
    push(1, d[63:32], d[111:96], 0, 0);
    e_bytes += 32'(d[111:96]); e_descs++; e_done = a[31:6];
    if (d[113]) push(1, cmpl_addr, 16'(AW/8), {a[31:6], 6'b0} | {30'b0, e_status | 2'b01}, 1);
    cont = 1;
  endtask

  task automatic add_chain(input logic [31:0] a);
    logic [31:0] n; bit c;
    forever begin
      add_desc(a, n, c);
      if (!c || n == 0) break;
      a = n;
    end
  endtask

  task automatic clr();
    g_n = 0; e_n = 0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) cmd_start = 1; else if (which == 1) cmd_append = 1; else cmd_reset = 1;
    @(negedge clk);
    cmd_start = 0; cmd_append = 0; cmd_reset = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy);
    @(negedge clk);
  endtask

  task automatic wait_log(input int n);
    while (g_n < n) @(negedge clk);
  endtask

  task automatic compare(input string tag);
    int m;
    chk(g_n == e_n, {tag, " request count"}, 64'(g_n), 64'(e_n));
    m = (g_n < e_n) ? g_n : e_n;
    for (int i = 0; i < m; i++) begin
      chk(g_wr[i] == e_wr[i] && g_addr[i] == e_addr[i] && g_len[i] == e_len[i],
          {tag, " request"}, {15'b0, g_wr[i], g_len[i], g_addr[i]}, {15'b0, e_wr[i], e_len[i], e_addr[i]});
      if (e_cw[i]) chk(g_wd[i] == e_wd[i], {tag, " completion word R4"}, 64'(g_wd[i]), 64'(e_wd[i]));
    end
  endtask

  task automatic state_chk(input string tag);
    chk(!busy, {tag, " busy"}, 64'(busy), 0);
    chk(xfer_status == e_status, {tag, " status"}, 64'(xfer_status), 64'(e_status));
    chk(err_flags == e_err, {tag, " err"}, 64'(err_flags), 64'(e_err));
    chk(done_addr == e_done, {tag, " done_addr R5"}, 64'(done_addr), 64'(e_done));
    chk(bytes_copied == e_bytes && descs_done == e_descs, {tag, " tallies R13"},
        {bytes_copied, descs_done}, {e_bytes, e_descs});
  endtask

  task automatic run_start(input logic [31:0] a, input string tag);
    clr(); e_status = 0; e_err = 0; add_chain(a);
    chain_addr = a; pulse(0); wait_idle();
    compare(tag); state_chk(tag);
  endtask

  initial begin
    logic [31:0] n; bit c;
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) dmem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!mem_req, "R1 mem_req", 64'(mem_req), 0);
    state_chk("R1");

    // R2 R3 R4 R5 R6 R13: three-entry chain, last at the length limit
    dmem[1] = mk(8'h02, 16'd32,  32'h8000, 32'h9000, 32'h80);
    dmem[2] = mk(8'h00, 16'd100, 32'h8100, 32'h9100, 32'hC0);
    dmem[3] = mk(8'h02, 16'(CAP), 32'hA000, 32'hB000, 32'h0);
    run_start(32'h40, "R6 chain");

    // R2: start while busy ignored
    dmem[4] = mk(8'h00, 16'd8, 32'h1111, 32'h2222, 32'h0);
    clr(); e_status = 0; e_err = 0; add_chain(32'h100);
    chain_addr = 32'h100; pulse(0);
    chain_addr = 32'h40; pulse(0);
    wait_idle(); compare("R2 start-while-busy"); state_chk("R2");

    // R7: null descriptor with a non-zero next
    dmem[5] = mk(8'h03, 16'd50, 32'h1, 32'h2, 32'h40);
    run_start(32'h140, "R7 null");

    // R8 bad flags, R9 over length, then clearing by start
    dmem[6] = mk(8'h10, 16'd4, 32'h3, 32'h4, 32'h0);
    run_start(32'h180, "R8 bad flags");
    dmem[7] = mk(8'h00, 16'(CAP + 1), 32'h3, 32'h4, 32'h0);
    run_start(32'h1C0, "R9 too long");
    dmem[8] = mk(8'h00, 16'd16, 32'h5000, 32'h6000, 32'h0);
    run_start(32'h200, "R9 err cleared");

    // R10: append while idle, then again with zero next
    dmem[8][31:0] = 32'h240;
    dmem[9] = mk(8'h02, 16'd20, 32'h5100, 32'h6100, 32'h0);
    clr(); push(0, 32'h200 + NOFS, 16'(AW/8), 0, 0); add_chain(32'h240);
    pulse(1); wait_idle(); compare("R10 append idle"); state_chk("R10");
    clr(); push(0, 32'h240 + NOFS, 16'(AW/8), 0, 0);
    pulse(1); wait_idle(); compare("R10 append zero next"); state_chk("R10 zero");

    // R11: append while busy, memory patched mid-descriptor
    dmem[10] = mk(8'h02, 16'd64, 32'h7000, 32'h7100, 32'h0);
    dmem[11] = mk(8'h00, 16'd12, 32'h7200, 32'h7300, 32'h0);
    clr(); e_status = 0; e_err = 0; add_desc(32'h280, n, c);
    push(0, 32'h280 + NOFS, 16'(AW/8), 0, 0); add_chain(32'h2C0);
    chain_addr = 32'h280; pulse(0); wait_log(2);
    dmem[10][31:0] = 32'h2C0; pulse(1);
    wait_idle(); compare("R11 held append"); state_chk("R11");
    // R11 priority: next pointer first, re-read after chain end
    dmem[12] = mk(8'h00, 16'd10, 32'h7400, 32'h7500, 32'h340);
    dmem[13] = mk(8'h00, 16'd11, 32'h7600, 32'h7700, 32'h0);
    clr(); e_status = 0; add_chain(32'h300); push(0, 32'h340 + NOFS, 16'(AW/8), 0, 0);
    chain_addr = 32'h300; pulse(0); wait_log(2); pulse(1);
    wait_idle(); compare("R11 next before append"); state_chk("R11 prio");

    // R12: reset idle, then held reset drops next and held append
    clr(); pulse(2); e_status = 3; @(negedge clk);
    chk(xfer_status == 2'd3 && !busy, "R12 idle reset", 64'(xfer_status), 3);
    dmem[14] = mk(8'h02, 16'd30, 32'h7800, 32'h7900, 32'h3C0);
    dmem[15] = mk(8'h00, 16'd31, 32'h7A00, 32'h7B00, 32'h0);
    clr(); e_status = 0; add_desc(32'h380, n, c); e_status = 3;
    chain_addr = 32'h380; pulse(0); wait_log(2); pulse(1); pulse(2);
    wait_idle(); compare("R12 held reset"); state_chk("R12");
    dmem[16] = mk(8'h00, 16'd9, 32'h7C00, 32'h7D00, 32'h0);
    run_start(32'h400, "R12 append dropped");

    // random chains
    for (int j = 0; j < 20; j++) begin
      int k; logic [31:0] a0;
      k = 1 + $urandom % 4;
      a0 = 32'((20 + (j * 4) % 44) * 64);
      for (int i = 0; i < k; i++) begin
        logic [15:0] l; logic [31:0] nx; int s;
        s = 20 + (j * 4 + i) % 44;
        l = ($urandom % 8 == 0) ? 16'(CAP + 1 + $urandom % 16) : 16'(1 + $urandom % CAP);
        nx = (i == k - 1) ? 32'h0 : 32'((20 + (j * 4 + i + 1) % 44) * 64);
        dmem[s] = mk({6'b0, 1'($urandom % 2), 1'b0}, l, $urandom, $urandom, nx);
      end
      cmpl_addr = {$urandom, 2'b00} >> 2;
      run_start(a0, "R3 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule